// File: doc/BRIEF.md
# Protected Single-Port RAM

This block wraps a register-array single-port memory with optional integrity protection. A caller raises `req` with `write`, `addr`, `wdata` and a bit-level `wmask`. A write updates the selected word. A read returns `rdata` together with a one-cycle `rvalid` strobe, a two-bit `rerror` status and an `alert` pulse. The block never stalls. Every request is accepted in the cycle it is presented, so there is no ready signal and no back-pressure. Each read produces exactly one response, and responses come back in request order.

Protection is chosen at elaboration time. With `USE_PARITY` the memory stores one even-parity bit beside each data byte. With `USE_SECDED` it stores a 7-bit odd-weight-column check field beside a 32-bit word. That code corrects any single flipped bit and detects any two flipped bits. Setting both options stops elaboration with an error, as do a SECDED width other than 32 and a parity width that is not a multiple of 8. Two optional register stages, `IN_REG` on the request side and `OUT_REG` on the response side, each add one cycle of read latency.

Top module: `prot_sp_ram`

## Requirements
- R1: `rvalid` rises exactly 1 + `IN_REG` + `OUT_REG` cycles after a read request is sampled. Each read yields one response, in order, and a write yields none.
- R2: While `rst_n` is low, `rvalid`, `rerror` and `alert` are all 0.
- R3: In parity mode, stored bit WIDTH+b holds the XOR of data byte b (bits 8b+7..8b). A byte whose stored parity disagrees on a read makes `rerror` 2'b10, and `rdata` is the stored data unchanged. Writing a byte rewrites its parity bit.
- R4: In SECDED mode every write carries an all-ones `wmask`. A word written this way reads back unchanged with `rerror` 2'b00.
- R5: In SECDED mode the stored word holds data in bits 31..0 and the check field in bits 38..32. A single flipped bit anywhere in those 39 bits returns the original data with `rerror` 2'b01.
- R6: Two flipped bits in a SECDED word return the raw stored data bits with `rerror` 2'b10. `alert` is high only in a cycle where `rvalid` is high and `rerror[1]` is set.
- R7: `rerror` is 2'b00 whenever `rvalid` is low, and on any read of an intact word. Bits 1 and 0 are never set together.
- R8: Outside SECDED mode, a write changes only the data bits whose `wmask` bit is 1. In parity mode the mask has byte granularity: all 8 mask bits of a byte are equal.
- R9: The `cfg` input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, one access per cycle |
| write | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| wdata | input | WIDTH | Write data |
| wmask | input | WIDTH | Per-bit write enable |
| cfg | input | CFG_W | Macro tuning input, ignored |
| rdata | output | WIDTH | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read response strobe |
| rerror | output | 2 | Bit 1 uncorrectable, bit 0 corrected |
| alert | output | 1 | Uncorrectable error on the current response |

## Verification
On every cycle, the assertions check the request-to-response latency, that error bits appear only with `rvalid` and never together, that `alert` accompanies an uncorrectable response, that parity mode never claims a correction, and that SECDED writes use a full mask. The bench scenarios cover what only stored contents can show: whether a corrupted word is repaired or reported, whether the returned data is corrected or raw, how masked byte writes merge and refresh parity, and that back-to-back reads through both pipeline stages come back in order.

// File: rtl/prot_ram_pkg.sv
package prot_ram_pkg;

  typedef enum logic [1:0] {
    PROT_NONE,
    PROT_PARITY,
    PROT_SECDED
  } prot_mode_e;

  localparam int unsigned EccDataW = 32;
  localparam int unsigned EccChkW  = 7;
  localparam int unsigned EccWordW = EccDataW + EccChkW;

  typedef logic [EccChkW-1:0] syn_t;

  typedef struct packed {
    logic [EccDataW-1:0] data;
    logic                fixed;
    logic                fatal;
  } ecc_res_t;

  function automatic int unsigned prot_store_width(input prot_mode_e mode,
                                                   input int unsigned width);
    case (mode)
      PROT_SECDED: return width + EccChkW;
      PROT_PARITY: return width + width / 8;
      default:     return width;
    endcase
  endfunction

  // The idx-th 7-bit value of weight three, in ascending order.
  function automatic syn_t ecc_column(input int unsigned idx);
    int unsigned seen;
    syn_t        col;
    seen = 0;
    col  = '0;
    for (int v = 0; v < 128; v++) begin
      if ($countones(v[6:0]) == 3) begin
        if (seen == idx) col = syn_t'(v);
        seen++;
      end
    end
    return col;
  endfunction

  function automatic syn_t ecc_checks(input logic [EccDataW-1:0] d);
    syn_t c;
    c = '0;
    for (int i = 0; i < EccDataW; i++) begin
      if (d[i]) c = c ^ ecc_column(i);
    end
    return c;
  endfunction

  function automatic ecc_res_t ecc_decode(input logic [EccWordW-1:0] word);
    syn_t     s;
    ecc_res_t r;
    logic     hit;
    s       = word[EccWordW-1:EccDataW] ^ ecc_checks(word[EccDataW-1:0]);
    r.data  = word[EccDataW-1:0];
    r.fixed = 1'b0;
    r.fatal = 1'b0;
    hit     = 1'b0;
    if (s != '0) begin
      if (^s) begin
        for (int i = 0; i < EccDataW; i++) begin
          if (s == ecc_column(i)) begin
            r.data[i] = ~r.data[i];
            hit       = 1'b1;
          end
        end
        if ($countones(s) == 1) hit = 1'b1;
        r.fixed = hit;
        r.fatal = ~hit;
      end else begin
        r.fatal = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/prot_ram_encode.sv
module prot_ram_encode
  import prot_ram_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter prot_mode_e  MODE  = PROT_SECDED,
  localparam int unsigned SW   = prot_store_width(MODE, WIDTH)
) (
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] wmask,
  output logic [SW-1:0]    word,
  output logic [SW-1:0]    bits
);

  if (MODE == PROT_SECDED) begin : g_secded
    always_comb begin
      word = {ecc_checks(wdata), wdata};
      bits = {{EccChkW{1'b1}}, wmask};
    end
  end else if (MODE == PROT_PARITY) begin : g_parity
    localparam int unsigned NB = WIDTH / 8;
    always_comb begin
      word[WIDTH-1:0] = wdata;
      bits[WIDTH-1:0] = wmask;
      for (int b = 0; b < NB; b++) begin
        word[WIDTH+b] = ^wdata[8*b +: 8];
        bits[WIDTH+b] = wmask[8*b];
      end
    end
  end else begin : g_plain
    assign word = wdata;
    assign bits = wmask;
  end

endmodule

// File: rtl/prot_ram_store.sv
module prot_ram_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned SW    = 39,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] wword,
  input  logic [SW-1:0] wbits,
  output logic [SW-1:0] rword
);

  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[addr] <= (mem[addr] & ~wbits) | (wword & wbits);
    end
    if (en && !we) begin
      rword <= mem[addr];
    end
  end

endmodule

// File: rtl/prot_ram_check.sv
module prot_ram_check
  import prot_ram_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter prot_mode_e  MODE  = PROT_SECDED,
  localparam int unsigned SW   = prot_store_width(MODE, WIDTH)
) (
  input  logic [SW-1:0]    word,
  output logic [WIDTH-1:0] data,
  output logic [1:0]       err
);

  if (MODE == PROT_SECDED) begin : g_secded
    ecc_res_t res;
    always_comb begin
      res  = ecc_decode(word);
      data = res.data;
      err  = {res.fatal, res.fixed};
    end
  end else if (MODE == PROT_PARITY) begin : g_parity
    localparam int unsigned NB = WIDTH / 8;
    logic [NB-1:0] bad;
    always_comb begin
      for (int b = 0; b < NB; b++) begin
        bad[b] = (^word[8*b +: 8]) ^ word[WIDTH+b];
      end
      data = word[WIDTH-1:0];
      err  = {|bad, 1'b0};
    end
  end else begin : g_plain
    assign data = word;
    assign err  = 2'b00;
  end

endmodule

// File: rtl/prot_sp_ram.sv
module prot_sp_ram
  import prot_ram_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned CFG_W      = 8,
  parameter bit          USE_PARITY = 1'b0,
  parameter bit          USE_SECDED = 1'b1,
  parameter bit          IN_REG     = 1'b0,
  parameter bit          OUT_REG    = 1'b0,
  localparam int unsigned AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             write,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] wmask,
  input  logic [CFG_W-1:0] cfg,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid,
  output logic [1:0]       rerror,
  output logic             alert
);

  localparam prot_mode_e  MODE = USE_SECDED ? PROT_SECDED :
                                 (USE_PARITY ? PROT_PARITY : PROT_NONE);
  localparam int unsigned SW   = prot_store_width(MODE, WIDTH);
  localparam int unsigned LAT  = 1 + int'(IN_REG) + int'(OUT_REG);

  if (USE_PARITY && USE_SECDED) begin : g_bad_both
    $error("prot_sp_ram: parity and SECDED cannot both be enabled");
  end
  if (USE_SECDED && WIDTH != EccDataW) begin : g_bad_ecc_width
    $error("prot_sp_ram: SECDED mode needs a 32-bit width");
  end
  if (USE_PARITY && (WIDTH % 8) != 0) begin : g_bad_par_width
    $error("prot_sp_ram: parity mode needs a whole number of bytes");
  end

  logic unused_cfg;
  assign unused_cfg = ^cfg;

  // Request stage
  logic             s_req, s_write;
  logic [AW-1:0]    s_addr;
  logic [WIDTH-1:0] s_wdata, s_wmask;

  if (IN_REG) begin : g_in_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_req   <= 1'b0;
        s_write <= 1'b0;
        s_addr  <= '0;
        s_wdata <= '0;
        s_wmask <= '0;
      end else begin
        s_req   <= req;
        s_write <= write;
        s_addr  <= addr;
        s_wdata <= wdata;
        s_wmask <= wmask;
      end
    end
  end else begin : g_in_pass
    assign s_req   = req;
    assign s_write = write;
    assign s_addr  = addr;
    assign s_wdata = wdata;
    assign s_wmask = wmask;
  end

  // Encode and store
  logic [SW-1:0] enc_word, enc_bits, rd_word;

  prot_ram_encode #(.WIDTH(WIDTH), .MODE(MODE)) u_enc (
    .wdata (s_wdata),
    .wmask (s_wmask),
    .word  (enc_word),
    .bits  (enc_bits)
  );

  prot_ram_store #(.DEPTH(DEPTH), .SW(SW)) u_mem (
    .clk   (clk),
    .en    (s_req),
    .we    (s_write),
    .addr  (s_addr),
    .wword (enc_word),
    .wbits (enc_bits),
    .rword (rd_word)
  );

  logic rd_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= s_req && !s_write;
  end

  // Decode
  logic [WIDTH-1:0] chk_data;
  logic [1:0]       chk_err, gated_err;

  prot_ram_check #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
    .word (rd_word),
    .data (chk_data),
    .err  (chk_err)
  );

  assign gated_err = rd_valid ? chk_err : 2'b00;

  // Response stage
  if (OUT_REG) begin : g_out_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rvalid <= 1'b0;
        rerror <= 2'b00;
        rdata  <= '0;
      end else begin
        rvalid <= rd_valid;
        rerror <= gated_err;
        rdata  <= chk_data;
      end
    end
  end else begin : g_out_pass
    assign rvalid = rd_valid;
    assign rerror = gated_err;
    assign rdata  = chk_data;
  end

  assign alert = rvalid && rerror[1];

  // Checks
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(since_rst) >= LAT) |-> (rvalid == $past(req && !write, LAT)));

  a_r7_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rerror != 2'b00) |-> rvalid);

  a_r7_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rerror[1] && rerror[0]));

  a_r6_alert_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> (rvalid && rerror[1]));

  if (MODE == PROT_SECDED) begin : g_ecc_chk
    a_r4_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (req && write) |-> (wmask == {WIDTH{1'b1}}));
  end
  if (MODE == PROT_PARITY) begin : g_par_chk
    a_r3_no_correction: assert property (@(posedge clk) disable iff (!rst_n)
      !rerror[0]);
  end

endmodule

// File: tb/sim_prot_sp_ram.sv
module sim_prot_sp_ram;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LAT0 = 3;
  localparam int LAT1 = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] d;
    logic [1:0]  e;
    int          at;
    string       tag;
  } item_t;

  item_t eq[$];
  item_t pq[$];

  // SECDED instance, both pipeline stages
  logic        e_req, e_write;
  logic [3:0]  e_addr;
  logic [31:0] e_wdata, e_wmask, e_rdata;
  logic [7:0]  e_cfg;
  logic        e_rvalid, e_alert;
  logic [1:0]  e_rerror;

  // Parity instance, no pipeline stages
  logic        p_req, p_write;
  logic [3:0]  p_addr;
  logic [31:0] p_wdata, p_wmask, p_rdata;
  logic [7:0]  p_cfg;
  logic        p_rvalid, p_alert;
  logic [1:0]  p_rerror;

  prot_sp_ram #(.DEPTH(16), .WIDTH(32), .CFG_W(8), .USE_PARITY(1'b0),
                .USE_SECDED(1'b1), .IN_REG(1'b1), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req(e_req), .write(e_write), .addr(e_addr),
    .wdata(e_wdata), .wmask(e_wmask), .cfg(e_cfg), .rdata(e_rdata),
    .rvalid(e_rvalid), .rerror(e_rerror), .alert(e_alert));

  prot_sp_ram #(.DEPTH(16), .WIDTH(32), .CFG_W(8), .USE_PARITY(1'b1),
                .USE_SECDED(1'b0), .IN_REG(1'b0), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req(p_req), .write(p_write), .addr(p_addr),
    .wdata(p_wdata), .wmask(p_wmask), .cfg(p_cfg), .rdata(p_rdata),
    .rvalid(p_rvalid), .rerror(p_rerror), .alert(p_alert));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic e_op(input bit wr, input logic [3:0] a, input logic [31:0] d,
                      input logic [31:0] xd, input logic [1:0] xe, input string tag);
    @(negedge clk);
    e_req = 1'b1; e_write = wr; e_addr = a; e_wdata = d; e_wmask = '1;
    if (!wr) eq.push_back('{xd, xe, cyc + LAT0, tag});
  endtask

  task automatic p_op(input bit wr, input logic [3:0] a, input logic [31:0] d,
                      input logic [31:0] m, input logic [31:0] xd,
                      input logic [1:0] xe, input string tag);
    @(negedge clk);
    p_req = 1'b1; p_write = wr; p_addr = a; p_wdata = d; p_wmask = m;
    if (!wr) pq.push_back('{xd, xe, cyc + LAT1, tag});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      e_req = 1'b0;
      p_req = 1'b0;
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Monitors: pop expected responses as the design delivers them
  always @(posedge clk) begin
    item_t it;
    #1;
    if (rst_n) begin
      if (e_rvalid) begin
        if (eq.size() == 0) chk(1'b0, "R1", "ecc rvalid without read", 1, 0);
        else begin
          it = eq.pop_front();
          chk(e_rdata == it.d, it.tag, "ecc rdata", e_rdata, it.d);
          chk(e_rerror == it.e, it.tag, "ecc rerror", e_rerror, it.e);
          chk(cyc == it.at, "R1", "ecc response cycle", cyc, it.at);
          chk(e_alert == it.e[1], "R6", "ecc alert", e_alert, it.e[1]);
        end
      end else begin
        if (e_alert) chk(1'b0, "R6", "ecc alert without rvalid", 1, 0);
        if (e_rerror != 2'b00) chk(1'b0, "R7", "ecc rerror without rvalid", e_rerror, 0);
      end
      if (p_rvalid) begin
        if (pq.size() == 0) chk(1'b0, "R1", "par rvalid without read", 1, 0);
        else begin
          it = pq.pop_front();
          chk(p_rdata == it.d, it.tag, "par rdata", p_rdata, it.d);
          chk(p_rerror == it.e, it.tag, "par rerror", p_rerror, it.e);
          chk(cyc == it.at, "R1", "par response cycle", cyc, it.at);
          chk(p_alert == it.e[1], "R6", "par alert", p_alert, it.e[1]);
        end
      end else begin
        if (p_alert) chk(1'b0, "R6", "par alert without rvalid", 1, 0);
        if (p_rerror != 2'b00) chk(1'b0, "R7", "par rerror without rvalid", p_rerror, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
  end

  initial begin
    e_req = 0; e_write = 0; e_addr = 0; e_wdata = 0; e_wmask = '1; e_cfg = 0;
    p_req = 0; p_write = 0; p_addr = 0; p_wdata = 0; p_wmask = '1; p_cfg = 0;
    repeat (3) @(negedge clk);
    // R2: outputs quiet in reset
    chk({e_rvalid, e_rerror, e_alert} == 4'b0, "R2", "ecc reset outputs",
        {e_rvalid, e_rerror, e_alert}, 0);
    chk({p_rvalid, p_rerror, p_alert} == 4'b0, "R2", "par reset outputs",
        {p_rvalid, p_rerror, p_alert}, 0);
    rst_n = 1'b1;
    idle(2);

    // SECDED: clean writes and back-to-back reads (R4, R1)
    e_op(1, 4'd3, 32'h1234_5678, 0, 0, "R4");
    e_op(1, 4'd7, 32'hCAFE_F00D, 0, 0, "R4");
    e_op(0, 4'd3, 0, 32'h1234_5678, 2'b00, "R4");
    e_op(0, 4'd7, 0, 32'hCAFE_F00D, 2'b00, "R4");
    e_op(1, 4'd5, 32'h0, 0, 0, "R1");
    e_op(0, 4'd3, 0, 32'h1234_5678, 2'b00, "R1");
    idle(6);

    // R5: single data bit flip is corrected
    u0.u_mem.mem[3][5] = ~u0.u_mem.mem[3][5];
    e_op(0, 4'd3, 0, 32'h1234_5678, 2'b01, "R5");
    idle(5);

    // R5: single check bit flip is corrected
    e_op(1, 4'd3, 32'h1234_5678, 0, 0, "R5");
    idle(5);
    u0.u_mem.mem[3][34] = ~u0.u_mem.mem[3][34];
    e_op(0, 4'd3, 0, 32'h1234_5678, 2'b01, "R5");
    idle(5);

    // R6: double flip is flagged, raw data returned, alert pulses
    e_op(1, 4'd3, 32'h1234_5678, 0, 0, "R6");
    idle(5);
    u0.u_mem.mem[3][0] = ~u0.u_mem.mem[3][0];
    u0.u_mem.mem[3][9] = ~u0.u_mem.mem[3][9];
    e_op(0, 4'd3, 0, 32'h1234_5479, 2'b10, "R6");
    e_op(0, 4'd7, 0, 32'hCAFE_F00D, 2'b00, "R7");
    idle(5);

    // R9: cfg has no effect
    e_cfg = 8'hFF;
    e_op(0, 4'd7, 0, 32'hCAFE_F00D, 2'b00, "R9");
    idle(5);

    // Parity: clean write and read (R7)
    p_op(1, 4'd1, 32'hAABB_CCDD, 32'hFFFF_FFFF, 0, 0, "R7");
    p_op(0, 4'd1, 0, 0, 32'hAABB_CCDD, 2'b00, "R7");
    // R8: byte-masked write merges
    p_op(1, 4'd1, 32'h1122_3344, 32'h0000_FF00, 0, 0, "R8");
    p_op(0, 4'd1, 0, 0, 32'hAABB_33DD, 2'b00, "R8");
    idle(3);

    // R3: data bit flip in byte 2 detected
    u1.u_mem.mem[1][17] = ~u1.u_mem.mem[1][17];
    p_cfg = 8'h5A;
    p_op(0, 4'd1, 0, 0, 32'hAAB9_33DD, 2'b10, "R3");
    idle(2);

    // R3: parity bit flip of byte 3 detected, then repaired by a byte write
    p_op(1, 4'd2, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 0, 0, "R3");
    idle(3);
    u1.u_mem.mem[2][35] = ~u1.u_mem.mem[2][35];
    p_op(0, 4'd2, 0, 0, 32'h0F0F_0F0F, 2'b10, "R3");
    p_op(1, 4'd2, 32'h8000_0000, 32'hFF00_0000, 0, 0, "R3");
    p_op(0, 4'd2, 0, 0, 32'h800F_0F0F, 2'b00, "R3");
    idle(6);

    chk(eq.size() == 0 && pq.size() == 0, "R1", "responses outstanding",
        eq.size() + pq.size(), 0);
    summary();
  end

endmodule